// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word. Bits enter one at a time on the rising edges of a shift clock and move through a chain of stages. A separate storage clock copies the whole chain into a storage register at once, so the parallel outputs change only when the storage clock says they should. Because of this, a new word can be shifted in while the previous one stays on the outputs.

The parallel outputs can be switched to high impedance with an active-low output enable. A flag that follows the drive state is also provided, because a two-state simulator cannot show a floating line. An active-low asynchronous clear empties the shift stages and leaves the storage register alone. The last stage is brought out as a serial output, so several blocks can be chained into one longer register.

Top module: `sipo_latched_top`

## Requirements
- R1: On each rising edge of `shift_clk` while `clr_n` is high, stage 0 takes `ser_in` and each stage n (n = 1..W-1) takes the previous value of stage n-1.
- R2: `ser_out` always equals the last stage (W-1), so after a shift it shows the old value of stage W-2. When the blocks are chained, after 2W shifts the first bit sent is on the second block's `ser_out`.
- R3: On a rising edge of `store_clk`, the storage register takes all W stage values, with stage i going to bit i. After 2W shifts of word w (bit 2W-1 sent first) through two chained blocks, the first block's parallel output is w[W-1:0] and the second block's is w[2W-1:W].
- R4: Driving `clr_n` low forces every shift stage, and therefore `ser_out`, to 0 at once, with no clock edge needed.
- R5: The clear does not change the storage register. The parallel outputs keep their value through a clear.
- R6: While `oe_n` is low, `par_q` shows the storage register and `drv_on` is 1.
- R7: While `oe_n` is high, `par_q` is high impedance on every bit and `drv_on` is 0.
- R8: If `shift_clk` and `store_clk` come from one signal, each edge stores the stage contents from before that edge, so the parallel outputs stay one shift behind the chain.
- R9: A `store_clk` edge after a clear, with no shift in between, loads all zeros into the storage register.
- R10: `shift_clk` edges with no `store_clk` edge leave `par_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock, rising edge |
| store_clk | input | 1 | Storage clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Output enable for the parallel lines, active low |
| par_q | output | W | Parallel outputs, high impedance when disabled |
| drv_on | output | 1 | 1 while the parallel lines are driven |
| ser_out | output | 1 | Last shift stage, used for chaining |

## Verification
The hardest case to reach from the ports is tied clocks: the storage register must catch the chain state from just before the same edge that shifts the chain. The bench routes one clock to both inputs of two chained blocks. It compares the 2W-bit parallel result after every edge with the chain contents its own model held one edge earlier. A second hard case is the clear that happens between a store and the next shift. The bench checks that the parallel word survives the clear, and that the following store edge loads zeros.

// File: rtl/sipo_pkg.sv
// Package: settings shared by the latched shift register and its checker.
// Assumes: nothing; it only holds constants.
package sipo_pkg;
    // Default number of stages in one block.
    localparam int unsigned SIPO_STAGES = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
// Module: serial shift chain with an asynchronous active-low clear.
// What it does: stage 0 loads the serial input and each later stage loads
// the stage before it, all on the rising edge of shift_clk.
// Assumes: W >= 2. The clear is asynchronous because the whole chain must
// empty with no shift edge.
module sipo_shift_chain #(
    parameter int unsigned W = 8
) (
    input  logic         shift_clk,
    input  logic         clr_n,
    input  logic         ser_in,
    output logic [W-1:0] stage_q
);
    localparam int unsigned LAST = W - 1;

    // Stage 0 takes the serial input.
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= ser_in;
    end

    // Later stages, one flop each, each fed by the stage below it.
    for (genvar n = 1; n <= LAST; n++) begin : g_stage
        // Move the value up by one stage.
        always_ff @(posedge shift_clk or negedge clr_n) begin
            if (!clr_n) stage_q[n] <= 1'b0;
            else        stage_q[n] <= stage_q[n-1];
        end
    end
endmodule

// File: rtl/sipo_store_bank.sv
// Module: storage register that copies the whole shift chain.
// What it does: on the rising edge of store_clk, each bit takes the
// matching stage value.
// Assumes: no reset of its own. The content is only defined after the
// first store edge.
module sipo_store_bank #(
    parameter int unsigned W = 8
) (
    input  logic         store_clk,
    input  logic [W-1:0] stage_i,
    output logic [W-1:0] store_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Copy one stage into its storage bit.
        always_ff @(posedge store_clk) begin
            store_q[i] <= stage_i[i];
        end
    end
endmodule

// File: rtl/sipo_out_gate.sv
// Module: output drive control for the parallel lines.
// What it does: gives a drive enable and a data value for each bit, and one
// flag that says whether the lines are driven.
// Assumes: the top level turns the enable and value into tri-state lines.
module sipo_out_gate #(
    parameter int unsigned W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] bit_en,
    output logic [W-1:0] bit_val,
    output logic         drive_on
);
    // The drive flag is high while the active-low enable is asserted.
    always_comb drive_on = ~oe_n;

    for (genvar i = 0; i < W; i++) begin : g_drv
        // Enable and value for one bit.
        always_comb begin
            bit_en[i]  = drive_on;
            bit_val[i] = data_i[i];
        end
    end
endmodule

// File: rtl/sipo_latched_top.sv
// Module: latched serial-to-parallel shift register (top level).
// What it does: a shift chain on shift_clk feeds a storage register on
// store_clk, which drives tri-state parallel lines. The last stage is
// brought out for chaining.
// Assumes: the clear acts asynchronously and only on the shift chain. The
// two clocks may be separate or driven by one signal.
module sipo_latched_top #(
    parameter int unsigned W = sipo_pkg::SIPO_STAGES
) (
    input  logic         ser_in,
    input  logic         shift_clk,
    input  logic         store_clk,
    input  logic         clr_n,
    input  logic         oe_n,
    output wire  [W-1:0] par_q,
    output logic         drv_on,
    output logic         ser_out
);
    localparam int unsigned LAST = W - 1;

    logic [W-1:0] stage_q;
    logic [W-1:0] store_q;
    logic [W-1:0] bit_en;
    logic [W-1:0] bit_val;

    sipo_shift_chain #(.W(W)) u_chain (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .stage_q   (stage_q)
    );

    sipo_store_bank #(.W(W)) u_store (
        .store_clk (store_clk),
        .stage_i   (stage_q),
        .store_q   (store_q)
    );

    sipo_out_gate #(.W(W)) u_gate (
        .oe_n     (oe_n),
        .data_i   (store_q),
        .bit_en   (bit_en),
        .bit_val  (bit_val),
        .drive_on (drv_on)
    );

    // Bring the last stage out for chaining.
    always_comb ser_out = stage_q[LAST];

    // Drive each parallel line, or leave it high impedance.
    for (genvar i = 0; i < W; i++) begin : g_pad
        assign par_q[i] = bit_en[i] ? bit_val[i] : 1'bz;
    end
endmodule

// File: rtl/sipo_latched_chk.sv
// Module: checker for the latched shift register, bound to every instance.
// What it does: checks the shift, serial output, store, clear and output
// enable rules against internal state and ports.
// Assumes: flags that record the first edge after a clear keep $past from
// looking back across a clear.
module sipo_latched_chk #(
    parameter int unsigned W = 8
) (
    input logic         shift_clk,
    input logic         store_clk,
    input logic         clr_n,
    input logic         oe_n,
    input logic         ser_in,
    input logic         ser_out,
    input logic         drv_on,
    input logic [W-1:0] par_q,
    input logic [W-1:0] stage_q,
    input logic [W-1:0] store_q
);
    logic sh_seen;
    logic st_seen;

    // Record that a shift edge has happened since the last clear.
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) sh_seen <= 1'b0;
        else        sh_seen <= 1'b1;
    end

    // Record that a store edge has happened since the last clear.
    always_ff @(posedge store_clk or negedge clr_n) begin
        if (!clr_n) st_seen <= 1'b0;
        else        st_seen <= 1'b1;
    end

    p_shift_step_r1: assert property (@(posedge shift_clk) disable iff (!clr_n)
        sh_seen |-> (stage_q == {$past(stage_q[W-2:0]), $past(ser_in)}));

    p_serial_out_r2: assert property (@(posedge shift_clk) disable iff (!clr_n)
        sh_seen |-> (ser_out == $past(stage_q[W-2])));

    p_store_copy_r3: assert property (@(posedge store_clk) disable iff (!clr_n)
        st_seen |-> (store_q == $past(stage_q)));

    p_clear_zero_r4: assert property (@(posedge store_clk)
        !clr_n |-> (stage_q == '0 && ser_out == 1'b0));

    p_par_shows_r6: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (st_seen && !oe_n) |-> (par_q == store_q));

    p_hiz_flag_r7: assert property (@(posedge shift_clk) disable iff (!clr_n)
        oe_n |-> !drv_on);
endmodule

bind sipo_latched_top sipo_latched_chk #(.W(W)) u_chk (
    .shift_clk (shift_clk),
    .store_clk (store_clk),
    .clr_n     (clr_n),
    .oe_n      (oe_n),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .drv_on    (drv_on),
    .par_q     (par_q),
    .stage_q   (stage_q),
    .store_q   (store_q)
);

// File: tb/test_sipo_latched_top.sv
// Bench: two blocks chained through the serial output and driven with
// hand-made clock pulses. A 16-bit arithmetic model gives every expected value.
module test_sipo_latched_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic ser_in = 1'b0;
    logic shift_clk = 1'b0;
    logic store_clk_r = 1'b0;
    logic tie = 1'b0;
    logic clr_n = 1'b1;
    logic oe_n = 1'b0;
    wire  store_clk = tie ? shift_clk : store_clk_r;

    wire [W-1:0] par_head, par_tail;
    logic        ser_head, ser_tail, drv_head, drv_tail;

    int checks = 0;
    int fails  = 0;
    logic [2*W-1:0] model = '0;

    sipo_latched_top #(.W(W)) i_sipo_latched_top (
        .ser_in (ser_in), .shift_clk (shift_clk), .store_clk (store_clk),
        .clr_n (clr_n), .oe_n (oe_n), .par_q (par_head),
        .drv_on (drv_head), .ser_out (ser_head)
    );

    sipo_latched_top #(.W(W)) i_sipo_latched_top_tail (
        .ser_in (ser_head), .shift_clk (shift_clk), .store_clk (store_clk),
        .clr_n (clr_n), .oe_n (oe_n), .par_q (par_tail),
        .drv_on (drv_tail), .ser_out (ser_tail)
    );

    task automatic check(input bit ok, input string req,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One shift pulse. The result is sampled once the clock is low again.
    task automatic shift_bit(input logic b);
        ser_in = b;
        #(CLK_PERIOD/2) shift_clk = 1'b1;
        #(CLK_PERIOD/2) shift_clk = 1'b0;
        model = {model[2*W-2:0], b};
    endtask

    task automatic store_pulse();
        #(CLK_PERIOD/2) store_clk_r = 1'b1;
        #(CLK_PERIOD/2) store_clk_r = 1'b0;
    endtask

    task automatic clear_pulse();
        #(CLK_PERIOD/2) clr_n = 1'b0;
        #1;
        model = '0;
        check({ser_tail, ser_head} == 2'b00, "R4 serial outputs during clear",
              {14'd0, ser_tail, ser_head}, '0);
        #(CLK_PERIOD/2) clr_n = 1'b1;
    endtask

    // Send w with bit 15 first, checking the serial outputs after every shift.
    task automatic send_word(input logic [2*W-1:0] w);
        for (int k = 2*W-1; k >= 0; k--) begin
            shift_bit(w[k]);
            check(ser_head == model[W-1], "R1 head stage W-1 after shift",
                  {15'd0, ser_head}, {15'd0, model[W-1]});
            check(ser_tail == model[2*W-1], "R2 chained serial output",
                  {15'd0, ser_tail}, {15'd0, model[2*W-1]});
        end
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [2*W-1:0] held;
        logic [2*W-1:0] w;
        logic [2*W-1:0] prev;
        bit have_held = 0;
        #1 clr_n = 1'b0;
        #1;
        check({ser_tail, ser_head} == 2'b00, "R4 reset clear",
              {14'd0, ser_tail, ser_head}, '0);
        #(CLK_PERIOD) clr_n = 1'b1;
        #(CLK_PERIOD);
        check({drv_tail, drv_head} == 2'b11, "R6 drive flag on",
              {14'd0, drv_tail, drv_head}, 16'd3);

        // Word sweep: fixed corner words, then arithmetic ones.
        held = '0;
        for (int p = 0; p < 28; p++) begin
            case (p)
                0: w = 16'h0001;
                1: w = 16'h8000;
                2: w = 16'hFFFF;
                3: w = 16'h0000;
                default: w = 16'(p * 40503 + 4660);
            endcase
            send_word(w);
            if (have_held)
                check({par_tail, par_head} == held, "R10 outputs held while shifting",
                      {par_tail, par_head}, held);
            store_pulse();
            check({par_tail, par_head} == w, "R3 chained parallel word",
                  {par_tail, par_head}, w);
            held = w;
            have_held = 1;
        end

        // Output enable.
        oe_n = 1'b1;
        #(CLK_PERIOD/2);
        check({drv_tail, drv_head} == 2'b00, "R7 high impedance flag",
              {14'd0, drv_tail, drv_head}, '0);
        oe_n = 1'b0;
        #(CLK_PERIOD/2);
        check({par_tail, par_head} == held, "R6 outputs restored",
              {par_tail, par_head}, held);

        // Clear leaves the storage register; a later store loads zeros.
        clear_pulse();
        check({par_tail, par_head} == held, "R5 storage survives clear",
              {par_tail, par_head}, held);
        store_pulse();
        check({par_tail, par_head} == '0, "R9 store after clear",
              {par_tail, par_head}, '0);

        // One clock on both inputs: storage stays one edge behind.
        tie = 1'b1;
        w = 16'hB4E7;
        for (int k = 0; k < 20; k++) begin
            prev = model;
            shift_bit(w[k % 16] ^ k[2]);
            check({par_tail, par_head} == prev, "R8 tied clocks one behind",
                  {par_tail, par_head}, prev);
        end
        tie = 1'b0;

        summary();
    end
endmodule